// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This unit performs the integer data-processing step of a simple execution pipeline. It takes an opcode, a first operand and an already-shifted second operand, and returns the result in the same cycle. For the arithmetic operations it also takes a carry value on `carry_in`. For the logical operations it takes the carry that the shifter produced, on `shift_carry`. The unit keeps a four-bit condition register (negative, zero, carry, overflow) that is loaded on the rising clock edge whenever a flag update is due.

Operations arrive on a valid-only issue interface. `in_valid` marks a cycle that carries an operation. There is no ready signal, because the unit accepts one operation in every cycle and never stalls. It therefore applies no back-pressure, and the upstream stage must not wait for one. `result` is combinational from the inputs in every cycle. `result_we` says whether the register file should write it. All subtract-type operations use carry as an inverted borrow: carry is 1 when no borrow occurred.

Top module: `dp_alu`

## Requirements
- R1: Opcode 2 gives `op_a + op_b` and opcode 3 gives `op_a + op_b + carry_in`, both modulo 2^WIDTH. The carry flag candidate is the carry out of bit WIDTH-1, so 0xFFFFFFFF + 0xFFFFFFFF gives 0xFFFFFFFE with carry 1.
- R2: Opcode 4 gives `op_a - op_b` and opcode 5 gives `op_a - op_b - (1 - carry_in)`. The carry candidate is 1 when the true difference is non-negative and 0 when a borrow occurred, so 4 - 8 gives 0xFFFFFFFC with carry 0.
- R3: Opcode 6 gives `op_b - op_a` and opcode 7 gives `op_b - op_a - (1 - carry_in)`, with the same inverted-borrow carry as R2.
- R4: The logical opcodes give the following results: opcode 0 passes `op_b`; opcode 1 gives `~op_b`; opcode 8 gives AND; opcode 9 gives OR; opcode 10 gives XOR; opcode 11 gives `op_a & ~op_b`.
- R5: Opcodes 12 (subtract as R2 opcode 4), 13 (add as R1 opcode 2), 14 (AND) and 15 (XOR) never assert `result_we`. When valid, they load the flags regardless of `set_flags`.
- R6: For opcodes 0 to 11, the flags load only when `in_valid` and `set_flags` are both 1. Otherwise all four flags hold their values.
- R7: When a logical opcode (0, 1, 8 to 11, 14, 15) loads the flags, N is set to result bit WIDTH-1 and Z to (result == 0). C is set to `shift_carry`, and V keeps its previous value.
- R8: When an arithmetic opcode (2 to 7, 12, 13) loads the flags, N and Z follow R7 and C is set to the carry candidate. V is set to 1 exactly when the signed value of the operation is outside the range of a signed WIDTH-bit number.
- R9: Reset (`rst_n` low) clears all four flags.
- R10: While `in_valid` is 0, `result_we` is 0 and the flags hold, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags load on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operation is issued this cycle |
| opcode | input | 4 | Operation select (see requirements) |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand, already shifted |
| carry_in | input | 1 | Carry used by the with-carry operations |
| shift_carry | input | 1 | Shifter carry-out, used as C by logical operations |
| set_flags | input | 1 | Request a flag update for opcodes 0 to 11 |
| result | output | WIDTH | Combinational operation result |
| result_we | output | 1 | Write strobe for `result` |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The main bench instance is built with WIDTH = 4. At that width a full sweep is small enough to run: every opcode against every operand pair, with every combination of `carry_in`, `set_flags` and `shift_carry`. The sweep therefore reaches every carry, borrow and signed-overflow boundary of the adder, and every hold-versus-update case of the flag register. A second instance with WIDTH = 32 checks the all-ones addition and the small-minus-large subtraction at full width, chains a with-carry subtraction onto the borrow that results, and runs an equal compare.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [3:0] {
    OP_PASS  = 4'd0,
    OP_PASSN = 4'd1,
    OP_ADD   = 4'd2,
    OP_ADDC  = 4'd3,
    OP_SUB   = 4'd4,
    OP_SUBC  = 4'd5,
    OP_RSUB  = 4'd6,
    OP_RSUBC = 4'd7,
    OP_AND   = 4'd8,
    OP_OR    = 4'd9,
    OP_XOR   = 4'd10,
    OP_CLR   = 4'd11,
    OP_CMP   = 4'd12,
    OP_CMPN  = 4'd13,
    OP_TST   = 4'd14,
    OP_TEQ   = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    CIN_ZERO,
    CIN_ONE,
    CIN_FLAG
  } cin_sel_e;

  typedef enum logic [2:0] {
    LG_AND,
    LG_OR,
    LG_XOR,
    LG_CLR,
    LG_PASS,
    LG_PASSN
  } lgc_sel_e;

  typedef struct packed {
    logic     arith;
    logic     swap;
    logic     inv_y;
    cin_sel_e cin;
    lgc_sel_e lop;
    logic     writes;
    logic     force_upd;
  } alu_ctl_t;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;

endpackage

// File: rtl/dp_alu_decode.sv
module dp_alu_decode
  import dp_alu_pkg::*;
(
  input  logic [3:0] opcode,
  output alu_ctl_t   ctl
);
  alu_op_e op;
  assign op = alu_op_e'(opcode);

  always_comb begin
    ctl = '{arith: 1'b0, swap: 1'b0, inv_y: 1'b0, cin: CIN_ZERO,
            lop: LG_AND, writes: 1'b1, force_upd: 1'b0};
    unique case (op)
      OP_PASS:  ctl.lop = LG_PASS;
      OP_PASSN: ctl.lop = LG_PASSN;
      OP_ADD:   ctl.arith = 1'b1;
      OP_ADDC:  begin ctl.arith = 1'b1; ctl.cin = CIN_FLAG; end
      OP_SUB:   begin ctl.arith = 1'b1; ctl.inv_y = 1'b1; ctl.cin = CIN_ONE; end
      OP_SUBC:  begin ctl.arith = 1'b1; ctl.inv_y = 1'b1; ctl.cin = CIN_FLAG; end
      OP_RSUB:  begin
                  ctl.arith = 1'b1; ctl.swap = 1'b1;
                  ctl.inv_y = 1'b1; ctl.cin = CIN_ONE;
                end
      OP_RSUBC: begin
                  ctl.arith = 1'b1; ctl.swap = 1'b1;
                  ctl.inv_y = 1'b1; ctl.cin = CIN_FLAG;
                end
      OP_AND:   ctl.lop = LG_AND;
      OP_OR:    ctl.lop = LG_OR;
      OP_XOR:   ctl.lop = LG_XOR;
      OP_CLR:   ctl.lop = LG_CLR;
      OP_CMP:   begin
                  ctl.arith = 1'b1; ctl.inv_y = 1'b1; ctl.cin = CIN_ONE;
                  ctl.writes = 1'b0; ctl.force_upd = 1'b1;
                end
      OP_CMPN:  begin
                  ctl.arith = 1'b1;
                  ctl.writes = 1'b0; ctl.force_upd = 1'b1;
                end
      OP_TST:   begin
                  ctl.lop = LG_AND;
                  ctl.writes = 1'b0; ctl.force_upd = 1'b1;
                end
      OP_TEQ:   begin
                  ctl.lop = LG_XOR;
                  ctl.writes = 1'b0; ctl.force_upd = 1'b1;
                end
      default:  ctl.lop = LG_AND;
    endcase
  end
endmodule

// File: rtl/dp_alu_addsub.sv
module dp_alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             ci,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] full;

  assign full = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, ci};
  assign sum  = full[MSB:0];
  assign cout = full[WIDTH];
  // Signed overflow of the effective addition x + y + ci
  assign ovf  = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  lgc_sel_e         lop,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] y
);
  always_comb begin
    unique case (lop)
      LG_AND:   y = a & b;
      LG_OR:    y = a | b;
      LG_XOR:   y = a ^ b;
      LG_CLR:   y = a & ~b;
      LG_PASS:  y = b;
      LG_PASSN: y = ~b;
      default:  y = '0;
    endcase
  end
endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags
  import dp_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd,
  input  logic       arith,
  input  alu_flags_t nxt,
  output alu_flags_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= nxt;
  end

  // R9
  flags_reset_chk: assert property (@(posedge clk) !rst_n |=> (q == '0));

  // R6
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> (q == $past(q)));

  // R7
  logic_v_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !arith) |=> (q.v == $past(q.v)));
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [3:0]       opcode,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  input  logic             shift_carry,
  input  logic             set_flags,
  output logic [WIDTH-1:0] result,
  output logic             result_we,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_c,
  output logic             flag_v
);
  localparam int MSB = WIDTH - 1;

  alu_ctl_t         ctl;
  logic [WIDTH-1:0] x, y_raw, y;
  logic             ci;
  logic [WIDTH-1:0] sum, lres;
  logic             cout, ovf;
  logic             upd;
  alu_flags_t       cur, nxt;

  dp_alu_decode u_dec (
    .opcode (opcode),
    .ctl    (ctl)
  );

  // Operand steering: reverse forms swap, subtract forms invert the subtrahend
  assign x     = ctl.swap ? op_b : op_a;
  assign y_raw = ctl.swap ? op_a : op_b;
  assign y     = ctl.inv_y ? ~y_raw : y_raw;

  always_comb begin
    unique case (ctl.cin)
      CIN_ONE:  ci = 1'b1;
      CIN_FLAG: ci = carry_in;
      default:  ci = 1'b0;
    endcase
  end

  dp_alu_addsub #(.WIDTH(WIDTH)) u_add (
    .x    (x),
    .y    (y),
    .ci   (ci),
    .sum  (sum),
    .cout (cout),
    .ovf  (ovf)
  );

  dp_alu_logic #(.WIDTH(WIDTH)) u_lgc (
    .lop (ctl.lop),
    .a   (op_a),
    .b   (op_b),
    .y   (lres)
  );

  assign result    = ctl.arith ? sum : lres;
  assign result_we = in_valid && ctl.writes;
  assign upd       = in_valid && (ctl.force_upd || set_flags);

  always_comb begin
    nxt.n = result[MSB];
    nxt.z = (result == '0);
    nxt.c = ctl.arith ? cout : shift_carry;
    nxt.v = ctl.arith ? ovf : cur.v;
  end

  dp_alu_flags u_flg (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (upd),
    .arith (ctl.arith),
    .nxt   (nxt),
    .q     (cur)
  );

  assign flag_n = cur.n;
  assign flag_z = cur.z;
  assign flag_c = cur.c;
  assign flag_v = cur.v;

  // R5
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (opcode >= 4'd12)) |-> !result_we);

  // R10
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !result_we);

  // R7
  logic_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !ctl.arith) |=> (flag_c == $past(shift_carry)));

  // R8
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (flag_z == ($past(result) == '0)));
endmodule

// File: tb/dp_alu_test.sv
`timescale 1ns/1ps
module dp_alu_test;
  localparam int W  = 4;
  localparam int M  = 1 << W;
  localparam int WW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          in_valid, carry_in, shift_carry, set_flags;
  logic [3:0]    opcode;
  logic [W-1:0]  op_a, op_b, result;
  logic          result_we, fn, fz, fc, fv;

  logic          w_valid, w_cin, w_sc, w_set;
  logic [3:0]    w_op;
  logic [WW-1:0] w_a, w_b, w_res;
  logic          w_we, w_n, w_z, w_c, w_v;

  dp_alu #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .op_a(op_a), .op_b(op_b), .carry_in(carry_in), .shift_carry(shift_carry),
    .set_flags(set_flags), .result(result), .result_we(result_we),
    .flag_n(fn), .flag_z(fz), .flag_c(fc), .flag_v(fv)
  );

  dp_alu #(.WIDTH(WW)) uut_w (
    .clk(clk), .rst_n(rst_n), .in_valid(w_valid), .opcode(w_op),
    .op_a(w_a), .op_b(w_b), .carry_in(w_cin), .shift_carry(w_sc),
    .set_flags(w_set), .result(w_res), .result_we(w_we),
    .flag_n(w_n), .flag_z(w_z), .flag_c(w_c), .flag_v(w_v)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [3:0] exp_flags = 4'b0000;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic string res_tag(input int op);
    if (op == 2 || op == 3) return "R1";
    if (op == 4 || op == 5) return "R2";
    if (op == 6 || op == 7) return "R3";
    if (op >= 12) return "R5";
    return "R4";
  endfunction

  function automatic int sgn(input int u);
    return (u >= M / 2) ? u - M : u;
  endfunction

  // One vector on the narrow instance, with the expected values computed here
  task automatic run_vec(input int op, input int a, input int b, input int ci,
                         input int s, input int sc, input int v);
    int r, raw, sraw, bw;
    bit ar, cc, vv, upd, we;
    logic [3:0] nf;
    ar = 0; cc = 0; vv = 0; r = 0;
    bw = 1 - ci;
    case (op)
      0: r = b;
      1: r = (~b) & (M - 1);
      2, 3, 13: begin
        ar = 1;
        raw = a + b + ((op == 3) ? ci : 0);
        sraw = sgn(a) + sgn(b) + ((op == 3) ? ci : 0);
        cc = raw >= M; r = raw % M;
        vv = (sraw < -M / 2) || (sraw > M / 2 - 1);
      end
      4, 5, 6, 7, 12: begin
        int p, q, k;
        ar = 1;
        p = (op == 6 || op == 7) ? b : a;
        q = (op == 6 || op == 7) ? a : b;
        k = (op == 5 || op == 7) ? bw : 0;
        raw = p - q - k;
        sraw = sgn(p) - sgn(q) - k;
        cc = raw >= 0; r = (raw + 2 * M) % M;
        vv = (sraw < -M / 2) || (sraw > M / 2 - 1);
      end
      8, 14: r = a & b;
      9: r = a | b;
      10, 15: r = a ^ b;
      11: r = a & (~b) & (M - 1);
      default: r = 0;
    endcase
    we  = v && (op < 12);
    upd = v && ((op >= 12) || s);

    @(negedge clk);
    in_valid = v[0]; opcode = op[3:0]; op_a = a[W-1:0]; op_b = b[W-1:0];
    carry_in = ci[0]; set_flags = s[0]; shift_carry = sc[0];
    #1;
    check(result == r[W-1:0], res_tag(op), result, r);
    check(result_we == we, v ? res_tag(op) : "R10", result_we, we);

    nf = exp_flags;
    if (upd) begin
      nf[3] = r[W-1];
      nf[2] = (r == 0);
      nf[1] = ar ? cc : sc[0];
      nf[0] = ar ? vv : exp_flags[0];
    end
    @(posedge clk); #1;
    check({fn, fz, fc, fv} == nf,
          !v ? "R10" : !upd ? "R6" : (op >= 12) ? "R5" : ar ? "R8" : "R7",
          {fn, fz, fc, fv}, nf);
    exp_flags = nf;
  endtask

  task automatic run_wide(input int op, input logic [WW-1:0] a, input logic [WW-1:0] b,
                          input bit ci, input logic [WW-1:0] exp_r, input bit exp_we,
                          input bit exp_c, input bit exp_z, input string tag);
    @(negedge clk);
    w_valid = 1; w_op = op[3:0]; w_a = a; w_b = b; w_cin = ci; w_set = 1; w_sc = 0;
    #1;
    check(w_res == exp_r, tag, w_res, exp_r);
    check(w_we == exp_we, tag, w_we, exp_we);
    @(posedge clk); #1;
    check(w_c == exp_c, tag, w_c, exp_c);
    check(w_z == exp_z, tag, w_z, exp_z);
    check(w_n == exp_r[WW-1], tag, w_n, exp_r[WW-1]);
    @(negedge clk); w_valid = 0;
  endtask

  initial begin
    in_valid = 0; opcode = 0; op_a = 0; op_b = 0;
    carry_in = 0; shift_carry = 0; set_flags = 0;
    w_valid = 0; w_op = 0; w_a = 0; w_b = 0; w_cin = 0; w_sc = 0; w_set = 0;
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    check({fn, fz, fc, fv} == 4'b0000, "R9", {fn, fz, fc, fv}, 0);
    check({w_n, w_z, w_c, w_v} == 4'b0000, "R9", {w_n, w_z, w_c, w_v}, 0);
    @(negedge clk); rst_n = 1;

    // Full sweep of the narrow instance
    for (int op = 0; op < 16; op++)
      for (int a = 0; a < M; a++)
        for (int b = 0; b < M; b++)
          for (int k = 0; k < 8; k++)
            run_vec(op, a, b, k & 1, (k >> 1) & 1, (k >> 2) & 1, 1);

    // R10: idle cycles write nothing and leave the flags alone
    for (int op = 0; op < 16; op++) run_vec(op, 0, 0, 1, 1, 1, 0);
    for (int op = 0; op < 16; op++) run_vec(op, 9, 12, 0, 1, 0, 0);

    // Wide instance: full-width corner cases
    run_wide(2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 32'hFFFF_FFFE, 1, 1, 0, "R1");
    run_wide(4, 32'd4, 32'd8, 0, 32'hFFFF_FFFC, 1, 0, 0, "R2");
    run_wide(5, 32'hFFFF_FFFC, 32'd2, 0, 32'hFFFF_FFF9, 1, 1, 0, "R2");
    run_wide(7, 32'd2, 32'd4, 0, 32'd1, 1, 1, 0, "R3");
    run_wide(12, 32'd7, 32'd7, 0, 32'd0, 0, 1, 1, "R5");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule